// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block holds a chain of flip-flop stages that is filled in one of two ways. In load mode, a whole byte from the parallel inputs is written into the chain on a single clock edge. In shift mode, a new serial bit enters the head of the chain on each edge, and every bit moves one place toward the tail. The tail stage is the only functional output. This makes the block a parallel-to-serial converter, or a serial delay line.

The system clock is meant to run freely. A hold input, sampled on the rising edge as a synchronous enable, freezes every stage, including a load that would otherwise take place. No gated clock net is produced. An active-low clear is asynchronous. It empties the chain at once, whatever the clock, hold or mode inputs are doing. A debug bus exposes all stages so that the chain can be observed.

Top module: `gated_shift_reg`

## Requirements
- R1: The chain has `WIDTH` stages (default 8), numbered 0 (head) to `WIDTH-1` (tail). `ser_o` always equals the tail stage, `stages_o[WIDTH-1]`. `stages_o[i]` shows stage i.
- R2: On a rising edge with `hold_i` low and `shift_mode_i` high, stage 0 takes `ser_i` and each stage i>0 takes the old value of stage i-1.
- R3: On a rising edge with `hold_i` low and `shift_mode_i` low, stage i takes `par_i[i]` for every i. `ser_i` has no effect on that edge.
- R4: Right after a load edge, `ser_o` equals the `par_i[WIDTH-1]` that was applied at that edge.
- R5: On a rising edge with `hold_i` high, every stage keeps its value, whatever `shift_mode_i`, `ser_i` and `par_i` are.
- R6: When `clr_n_i` goes low, all stages become 0 without waiting for a clock edge.
- R7: While `clr_n_i` is low, rising edges leave every stage at 0, whatever the other inputs are.
- R8: When `clr_n_i` is released between edges, the next rising edge performs a normal load or shift.
- R9: Shift in eight bits b0 first through b7 last. After the eighth shift edge, `ser_o` shows b0. Each further shift edge then shows b1 through b7 in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock, rising edge active |
| clr_n_i | input | 1 | Asynchronous clear, active low |
| shift_mode_i | input | 1 | 1 = serial shift, 0 = parallel load |
| hold_i | input | 1 | 1 = freeze all stages at the edge |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data, bit i goes to stage i |
| ser_o | output | 1 | Tail stage value |
| stages_o | output | WIDTH | Debug view of all stages |

## Verification
A table of vectors mixes loads of unlike bytes (A5, 3C, 81), shifts with serial ones and zeros, and held edges in both modes. This separates a correct shift direction from a reversed one, and a correct load bit order from a mirrored one. The table also exposes a hold that is ignored or that lets only a load through. An eight-bit serial stream, 1011_0010 sent LSB first, checks that the bits leave the tail in arrival order. Clear is dropped between edges while the chain holds FF, then held low across active edges, then released between edges before a load and a shift. This tells a truly asynchronous clear apart from a synchronous one, and shows that release takes effect cleanly.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    // Operation applied to every stage at the next active edge
    typedef enum logic [1:0] {
        GSR_OP_HOLD  = 2'd0,
        GSR_OP_LOAD  = 2'd1,
        GSR_OP_SHIFT = 2'd2
    } gsr_op_e;

endpackage

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
    import gsr_pkg::*;
(
    input  logic    shift_mode_i,
    input  logic    hold_i,
    output gsr_op_e op_o
);

    // Hold wins over mode: a frozen chain neither loads nor shifts
    always_comb begin
        if (hold_i) begin
            op_o = GSR_OP_HOLD;
        end else if (shift_mode_i) begin
            op_o = GSR_OP_SHIFT;
        end else begin
            op_o = GSR_OP_LOAD;
        end
    end

endmodule

// File: rtl/gsr_stage.sv
module gsr_stage
    import gsr_pkg::*;
(
    input  gsr_op_e op_i,
    input  logic    cur_i,
    input  logic    prev_i,
    input  logic    par_i,
    output logic    nxt_o
);

    always_comb begin
        unique case (op_i)
            GSR_OP_LOAD:  nxt_o = par_i;
            GSR_OP_SHIFT: nxt_o = prev_i;
            default:      nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/gated_shift_reg.sv
module gated_shift_reg
    import gsr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             clr_n_i,
    input  logic             shift_mode_i,
    input  logic             hold_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o,
    output logic [WIDTH-1:0] stages_o
);

    localparam int unsigned TAIL = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_state_t;

    chain_state_t state_d;
    chain_state_t state_q;

    gsr_op_e          op;
    logic [WIDTH-1:0] pred_bits;
    logic [WIDTH-1:0] next_bits;

    gsr_ctrl u_ctrl (
        .shift_mode_i (shift_mode_i),
        .hold_i       (hold_i),
        .op_o         (op)
    );

    // Predecessor of stage i: serial input for the head, stage i-1 otherwise
    assign pred_bits = {state_q.bits[TAIL-1:0], ser_i};

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        gsr_stage u_stage (
            .op_i   (op),
            .cur_i  (state_q.bits[i]),
            .prev_i (pred_bits[i]),
            .par_i  (par_i[i]),
            .nxt_o  (next_bits[i])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.bits = next_bits;
    end

    always_ff @(posedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ser_o    = state_q.bits[TAIL];
    assign stages_o = state_q.bits;

endmodule

// File: rtl/gated_shift_reg_chk.sv
module gated_shift_reg_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk_i,
    input logic             clr_n_i,
    input logic             shift_mode_i,
    input logic             hold_i,
    input logic             ser_i,
    input logic [WIDTH-1:0] par_i,
    input logic             ser_o,
    input logic [WIDTH-1:0] stages_o
);

    AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (!hold_i && shift_mode_i) |=> stages_o == {$past(stages_o[WIDTH-2:0]), $past(ser_i)}); // R2

    AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (!hold_i && !shift_mode_i) |=> stages_o == $past(par_i)); // R3

    AST_LOAD_TAIL_OUT: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        (!hold_i && !shift_mode_i) |=> ser_o == $past(par_i[WIDTH-1])); // R4

    AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!clr_n_i)
        hold_i |=> $stable(stages_o)); // R5

    always @(posedge clk_i) begin
        if (!clr_n_i) begin
            AST_CLEAR_ZERO: assert (stages_o == '0 && ser_o == 1'b0); // R7
        end
    end

endmodule

bind gated_shift_reg gated_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i        (clk_i),
    .clr_n_i      (clr_n_i),
    .shift_mode_i (shift_mode_i),
    .hold_i       (hold_i),
    .ser_i        (ser_i),
    .par_i        (par_i),
    .ser_o        (ser_o),
    .stages_o     (stages_o)
);

// File: tb/gated_shift_reg_tb_top.sv
`timescale 1ns/1ps
module gated_shift_reg_tb_top;

    localparam int unsigned W = 8;
    localparam int unsigned NVEC = 9;

    typedef struct packed {
        logic         mode;
        logic         hold;
        logic         ser;
        logic [W-1:0] par;
        logic [W-1:0] exp;
    } vec_t;

    // Starting from an empty chain; each row is one edge
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5},  // load
        '{1'b1, 1'b0, 1'b0, 8'h00, 8'h4A},  // shift 0
        '{1'b1, 1'b0, 1'b1, 8'hFF, 8'h95},  // shift 1
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'h95},  // held, shift mode
        '{1'b0, 1'b1, 1'b1, 8'hFF, 8'h95},  // held, load mode
        '{1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C},  // load, serial ignored
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h79},  // shift 1
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'hF3},  // shift 1
        '{1'b0, 1'b0, 1'b0, 8'h81, 8'h81}   // load
    };

    logic         clk = 1'b0;
    logic         clr_n;
    logic         mode;
    logic         hold;
    logic         ser;
    logic [W-1:0] par;
    logic         ser_o;
    logic [W-1:0] stages_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gated_shift_reg #(.WIDTH(W)) dut_i (
        .clk_i        (clk),
        .clr_n_i      (clr_n),
        .shift_mode_i (mode),
        .hold_i       (hold),
        .ser_i        (ser),
        .par_i        (par),
        .ser_o        (ser_o),
        .stages_o     (stages_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic h, input logic s, input logic [W-1:0] p);
        mode = m;
        hold = h;
        ser  = s;
        par  = p;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] pat;
        logic [W-1:0] rev;
        clr_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, '0);
        #0.5 clr_n = 1'b0;
        #1;
        chk("R6 reset state", stages_o, '0);
        drive(1'b0, 1'b0, 1'b1, 8'hFF);
        tick();
        tick();
        chk("R7 edges under clear", stages_o, '0);
        clr_n = 1'b1;

        // Vector table; first row is also the first edge after release (R8)
        for (int k = 0; k < NVEC; k++) begin
            drive(VECS[k].mode, VECS[k].hold, VECS[k].ser, VECS[k].par);
            tick();
            chk($sformatf("R2 R3 R5 R8 vector %0d stages", k), stages_o, VECS[k].exp);
            chk($sformatf("R1 R4 vector %0d ser_o", k), {7'b0, ser_o}, {7'b0, VECS[k].exp[W-1]});
        end

        // Hold across several edges while other inputs change
        drive(1'b0, 1'b0, 1'b0, 8'hC3);
        tick();
        for (int k = 0; k < 5; k++) begin
            drive(k[0], 1'b1, ~k[0], 8'h11 << k[2:0]);
            tick();
            chk($sformatf("R5 hold edge %0d", k), stages_o, 8'hC3);
        end

        // Serial stream, bit 0 enters first
        pat = 8'b1011_0010;
        for (int k = 0; k < W; k++) begin
            drive(1'b1, 1'b0, pat[k], 8'hFF);
            tick();
        end
        for (int j = 0; j < W; j++) rev[j] = pat[W-1-j];
        chk("R2 R9 stages after eight shifts", stages_o, rev);
        chk("R9 first bit at tail", {7'b0, ser_o}, {7'b0, pat[0]});
        for (int k = 1; k < W; k++) begin
            drive(1'b1, 1'b0, 1'b0, 8'h00);
            tick();
            chk($sformatf("R9 stream bit %0d", k), {7'b0, ser_o}, {7'b0, pat[k]});
        end

        // Clear between edges, then held, then released between edges
        drive(1'b0, 1'b0, 1'b0, 8'hFF);
        tick();
        chk("R3 load FF", stages_o, 8'hFF);
        #1 clr_n = 1'b0;
        #1;
        chk("R6 async clear stages", stages_o, '0);
        chk("R6 async clear ser_o", {7'b0, ser_o}, 8'h00);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 8'hFF);
        tick();
        drive(1'b1, 1'b0, 1'b1, 8'hFF);
        tick();
        chk("R7 clear beats load and shift", stages_o, '0);
        #0.5 clr_n = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 8'h5A);
        tick();
        chk("R8 load after release", stages_o, 8'h5A);
        drive(1'b1, 1'b0, 1'b1, 8'h00);
        tick();
        chk("R2 shift after release", stages_o, 8'hB5);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule